// File: doc/BRIEF.md
# Interrupt and Trap Sequencer

This block sits beside the retirement stage of an out-of-order core and serves one hardware thread. It catches an incoming interrupt request early and tells the front end to stop fetching. It then waits until the reorder buffer has fully drained and no store is still waiting for write-back. Only at that point does it enter the interrupt: it acknowledges the requester, raises a trap-pending status and starts a countdown whose length comes from a latency input.

When the countdown ends, the block issues a one-cycle trap squash and puts the thread into a squashing state. A separate thread-context squash request is turned into its own one-cycle squash pulse. That request is refused while a trap is in flight. The trap squash always has priority over a context squash.

Top module: `ints_trap_sequencer`

## Requirements
- R1: While synchronous active-high `rst` is high, every output is held at zero, and no state survives the reset.
- R2: An interrupt request is latched when `irq_req` and `irq_enable` are both high, no interrupt is already held, no trap is pending and no context squash is outstanding. `irq_to_fetch` rises in the cycle after the request cycle. A request made while `irq_enable` is low, or while `trap_pending` is high, is ignored.
- R3: A latched interrupt keeps `irq_to_fetch` high and `trap_pending` low for as long as `rob_empty` is low or `stores_pending` is high.
- R4: The interrupt is entered at the first clock edge at which it is held, `rob_empty` is high and `stores_pending` is low. In the cycle after that edge, `irq_ack` is high for exactly one cycle and carries the latched cause on `irq_ack_cause`, `trap_pending` rises, and `irq_to_fetch` falls.
- R5: `trap_latency` is captured at entry. If `irq_ack` is high in cycle A and the captured latency is L, then `trap_squash` is high in cycle A+L+2. Later changes to `trap_latency` have no effect on a trap already in flight. A second trap is never started while one is in flight.
- R6: With a captured latency of zero, `trap_squash` is high in cycle A+2.
- R7: In the cycle where `trap_squash` is high, `trap_pending` is low and `thread_squashing` is high.
- R8: If `ctx_squash_req` is high in cycle k while no trap is in flight, `ctx_squash` is high for one cycle in cycle k+2 and `thread_squashing` rises with it. A request made while `trap_pending` is high is dropped.
- R9: `thread_squashing` stays high until the first clock edge at which `rob_empty` is sampled high, and is low in the cycle after that edge.
- R10: `trap_squash` and `ctx_squash` are never high in the same cycle. A pending trap squash is always served before a context squash.
- R11: `trap_squash` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request from the controller |
| irq_cause | input | CAUSE_W | Cause code that accompanies the request |
| irq_enable | input | 1 | High when interrupts may be taken |
| rob_empty | input | 1 | Reorder buffer holds no instructions |
| stores_pending | input | 1 | Stores are still waiting for write-back |
| ctx_squash_req | input | 1 | Thread-context squash request |
| trap_latency | input | LAT_W | Countdown length from entry to trap squash |
| irq_to_fetch | output | 1 | Interrupt held; fetch must stop |
| irq_ack | output | 1 | One-cycle pulse clearing the request at entry |
| irq_ack_cause | output | CAUSE_W | Cause code of the entered interrupt |
| trap_pending | output | 1 | A trap has been entered and not yet squashed |
| trap_squash | output | 1 | One-cycle trap squash pulse |
| ctx_squash | output | 1 | One-cycle thread-context squash pulse |
| thread_squashing | output | 1 | Thread is in the squashing state |

## Verification
The hardest case to reach is a context squash request that arrives in the very cycle the interrupt is entered. In that cycle the trap has not yet started, so the request is still accepted, and two squash sources then race through the arbiter. The stimulus holds the reorder buffer empty, raises an interrupt, and raises the context request exactly one cycle later. This makes the entry edge and the acceptance edge the same edge. The scoreboard then expects the context pulse first and the trap pulse afterwards, never together. A second sequence raises both a new interrupt and a context request while a long trap countdown is running, and confirms that neither has any effect at the ports.

// File: rtl/ints_seq_pkg.sv
package ints_seq_pkg;

   // Which source the squash arbiter serves in a cycle.
   typedef enum logic [1:0] {
      SQ_NONE = 2'd0,
      SQ_TRAP = 2'd1,
      SQ_CTX  = 2'd2
   } sq_src_e;

   // Entry condition: interrupt held, buffer drained, no store write-back left.
   function automatic logic drain_done(input logic held,
                                       input logic empty,
                                       input logic st_wait);
      return held & empty & ~st_wait;
   endfunction

endpackage

// File: rtl/ints_irq_latch.sv
module ints_irq_latch #(
   parameter int CAUSE_W = 6
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               irq_req,
   input  logic               irq_enable,
   input  logic [CAUSE_W-1:0] irq_cause,
   input  logic               sample_ok,
   input  logic               rob_empty,
   input  logic               stores_pending,
   output logic               held,
   output logic               enter,
   output logic               ack,
   output logic [CAUSE_W-1:0] ack_cause
);
   import ints_seq_pkg::*;

   logic [CAUSE_W-1:0] cause_q;

   always_comb enter = drain_done(held, rob_empty, stores_pending);

   always_ff @(posedge clk) begin
      if (rst) begin
         held      <= 1'b0;
         cause_q   <= '0;
         ack       <= 1'b0;
         ack_cause <= '0;
      end else begin
         ack <= enter;
         if (enter) begin
            held      <= 1'b0;
            ack_cause <= cause_q;
         end else if (!held && sample_ok && irq_req && irq_enable) begin
            held    <= 1'b1;
            cause_q <= irq_cause;
         end
      end
   end

   // Entry acknowledge only follows a cycle with a drained buffer.
   assert_enter_needs_drain_R4: assert property (@(posedge clk) disable iff (rst)
      ack |-> $past(rob_empty && !stores_pending));

   // A held interrupt persists while draining is incomplete.
   assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (held && !(rob_empty && !stores_pending)) |=> held);

endmodule

// File: rtl/ints_trap_timer.sv
module ints_trap_timer #(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [LAT_W-1:0] latency,
   input  logic             clear,
   output logic             in_flight,
   output logic             expired
);
   logic [LAT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_flight <= 1'b0;
         expired   <= 1'b0;
         cnt       <= '0;
      end else if (start) begin
         in_flight <= 1'b1;
         expired   <= 1'b0;
         cnt       <= latency;
      end else if (clear) begin
         in_flight <= 1'b0;
         expired   <= 1'b0;
      end else if (in_flight && !expired) begin
         if (cnt == '0) expired <= 1'b1;
         else           cnt     <= cnt - 1'b1;
      end
   end

   // No trap may be scheduled while one is in flight.
   assert_no_restart_R5: assert property (@(posedge clk) disable iff (rst)
      start |-> !in_flight);

   // Expiry is only ever reported for a trap in flight.
   assert_expire_inflight_R6: assert property (@(posedge clk) disable iff (rst)
      expired |-> in_flight);

endmodule

// File: rtl/ints_squash_ctl.sv
module ints_squash_ctl (
   input  logic clk,
   input  logic rst,
   input  logic trap_req,
   input  logic in_flight,
   input  logic tc_req,
   input  logic rob_empty,
   output logic trap_clear,
   output logic tc_pending,
   output logic trap_squash,
   output logic ctx_squash,
   output logic squashing
);
   import ints_seq_pkg::*;

   sq_src_e sel;

   always_comb begin
      if (trap_req)        sel = SQ_TRAP;
      else if (tc_pending) sel = SQ_CTX;
      else                 sel = SQ_NONE;
      trap_clear = (sel == SQ_TRAP);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tc_pending  <= 1'b0;
         trap_squash <= 1'b0;
         ctx_squash  <= 1'b0;
         squashing   <= 1'b0;
      end else begin
         trap_squash <= (sel == SQ_TRAP);
         ctx_squash  <= (sel == SQ_CTX);
         if (sel == SQ_CTX)
            tc_pending <= 1'b0;
         else if (tc_req && !in_flight && !tc_pending)
            tc_pending <= 1'b1;
         if (sel != SQ_NONE)
            squashing <= 1'b1;
         else if (squashing && rob_empty)
            squashing <= 1'b0;
      end
   end

   // Both squash sources pending together is illegal.
   assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
      !(trap_req && tc_pending));

   assert_trap_pulse_R11: assert property (@(posedge clk) disable iff (rst)
      trap_squash |=> !trap_squash);

   // A context squash never comes from a request made during a trap.
   assert_ctx_blocked_R8: assert property (@(posedge clk) disable iff (rst)
      ctx_squash |-> !$past(in_flight, 2));

   assert_squash_state_R7: assert property (@(posedge clk) disable iff (rst)
      trap_squash |-> squashing);

endmodule

// File: rtl/ints_trap_sequencer.sv
module ints_trap_sequencer #(
   parameter int CAUSE_W = 6,
   parameter int LAT_W   = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               irq_req,
   input  logic [CAUSE_W-1:0] irq_cause,
   input  logic               irq_enable,
   input  logic               rob_empty,
   input  logic               stores_pending,
   input  logic               ctx_squash_req,
   input  logic [LAT_W-1:0]   trap_latency,
   output logic               irq_to_fetch,
   output logic               irq_ack,
   output logic [CAUSE_W-1:0] irq_ack_cause,
   output logic               trap_pending,
   output logic               trap_squash,
   output logic               ctx_squash,
   output logic               thread_squashing
);
   generate
      if (CAUSE_W < 1 || LAT_W < 1) begin : g_bad_cfg
         $error("ints_trap_sequencer: CAUSE_W and LAT_W must be at least 1");
      end
   endgenerate

   logic held, enter, sample_ok;
   logic in_flight, expired, trap_clear, tc_pending;

   assign sample_ok    = !in_flight && !tc_pending;
   assign irq_to_fetch = held;
   assign trap_pending = in_flight;

   ints_irq_latch #(.CAUSE_W(CAUSE_W)) u_latch (
      .clk            (clk),
      .rst            (rst),
      .irq_req        (irq_req),
      .irq_enable     (irq_enable),
      .irq_cause      (irq_cause),
      .sample_ok      (sample_ok),
      .rob_empty      (rob_empty),
      .stores_pending (stores_pending),
      .held           (held),
      .enter          (enter),
      .ack            (irq_ack),
      .ack_cause      (irq_ack_cause)
   );

   ints_trap_timer #(.LAT_W(LAT_W)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .start     (enter),
      .latency   (trap_latency),
      .clear     (trap_clear),
      .in_flight (in_flight),
      .expired   (expired)
   );

   ints_squash_ctl u_ctl (
      .clk         (clk),
      .rst         (rst),
      .trap_req    (expired),
      .in_flight   (in_flight),
      .tc_req      (ctx_squash_req),
      .rob_empty   (rob_empty),
      .trap_clear  (trap_clear),
      .tc_pending  (tc_pending),
      .trap_squash (trap_squash),
      .ctx_squash  (ctx_squash),
      .squashing   (thread_squashing)
   );

   // Fetch notice never rises out of a cycle with a trap pending.
   assert_sample_gate_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_to_fetch) |-> !$past(trap_pending));

   // Entry drops the fetch notice and raises trap status together.
   assert_entry_handoff_R4: assert property (@(posedge clk) disable iff (rst)
      irq_ack |-> (trap_pending && !irq_to_fetch));

endmodule

// File: tb/test_ints_trap_sequencer.sv
`timescale 1ns/1ps
module test_ints_trap_sequencer;
   localparam int CW = 6;
   localparam int LW = 8;

   logic clk = 1'b0;
   logic rst;
   logic irq_req, irq_enable, rob_empty, stores_pending, ctx_squash_req;
   logic [CW-1:0] irq_cause;
   logic [LW-1:0] trap_latency;
   logic irq_to_fetch, irq_ack, trap_pending, trap_squash, ctx_squash, thread_squashing;
   logic [CW-1:0] irq_ack_cause;

   int cyc = 0;
   int tests = 0;
   int fails = 0;
   bit done = 0;

   typedef struct {int kind; int cyc; int data;} ev_t;
   ev_t exp_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ints_trap_sequencer #(.CAUSE_W(CW), .LAT_W(LW)) i_ints_trap_sequencer (
      .clk(clk), .rst(rst), .irq_req(irq_req), .irq_cause(irq_cause),
      .irq_enable(irq_enable), .rob_empty(rob_empty), .stores_pending(stores_pending),
      .ctx_squash_req(ctx_squash_req), .trap_latency(trap_latency),
      .irq_to_fetch(irq_to_fetch), .irq_ack(irq_ack), .irq_ack_cause(irq_ack_cause),
      .trap_pending(trap_pending), .trap_squash(trap_squash), .ctx_squash(ctx_squash),
      .thread_squashing(thread_squashing)
   );

   task automatic check(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic push(input int kind, input int c, input int d);
      ev_t e;
      e.kind = kind; e.cyc = c; e.data = d;
      exp_q.push_back(e);
   endtask

   function automatic string kind_tag(input int kind);
      if (kind == 0) return "R4 ack";
      if (kind == 1) return "R5 trap_squash";
      return "R8 ctx_squash";
   endfunction

   // Monitor: every pulse seen must match a queued expectation.
   task automatic observe(input int kind, input int data);
      int idx = -1;
      for (int i = 0; i < exp_q.size(); i++)
         if (idx < 0 && exp_q[i].kind == kind) idx = i;
      tests++;
      if (idx < 0) begin
         fails++;
         $display("FAIL %s unexpected pulse actual=cycle %0d expected=none", kind_tag(kind), cyc);
      end else begin
         if (exp_q[idx].cyc != cyc || exp_q[idx].data != data) begin
            fails++;
            $display("FAIL %s actual=cycle %0d data %0d expected=cycle %0d data %0d",
                     kind_tag(kind), cyc, data, exp_q[idx].cyc, exp_q[idx].data);
         end
         exp_q.delete(idx);
      end
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         if (irq_ack)     observe(0, int'(irq_ack_cause));
         if (trap_squash) observe(1, 0);
         if (ctx_squash)  observe(2, 0);
      end
   end

   task automatic wait_until(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // Watchdog
   always @(posedge clk) begin
      if (cyc > 20000 && !done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL R1 watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      int k, m;
      rst = 1; irq_req = 0; irq_enable = 1; rob_empty = 1; stores_pending = 0;
      ctx_squash_req = 0; irq_cause = '0; trap_latency = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 irq_to_fetch", irq_to_fetch, 0);
      check("R1 irq_ack", irq_ack, 0);
      check("R1 trap_pending", trap_pending, 0);
      check("R1 squash outputs", {trap_squash, ctx_squash, thread_squashing}, 0);
      rst = 0;
      repeat (2) @(negedge clk);

      // Drained buffer, latency 3
      k = cyc; irq_req = 1; irq_cause = 6'd5; trap_latency = 8'd3;
      push(0, k + 2, 5); push(1, k + 7, 0);
      @(negedge clk); irq_req = 0;
      check("R2 irq_to_fetch after request", irq_to_fetch, 1);
      wait_until(k + 2);
      check("R4 trap_pending at entry", trap_pending, 1);
      check("R4 irq_to_fetch drops at entry", irq_to_fetch, 0);
      wait_until(k + 6);
      check("R5 trap_pending during countdown", trap_pending, 1);
      wait_until(k + 7);
      check("R7 trap_pending cleared by squash", trap_pending, 0);
      check("R7 thread_squashing with trap squash", thread_squashing, 1);
      wait_until(k + 8);
      check("R9 squashing ends on empty buffer", thread_squashing, 0);
      check("R11 trap_squash single cycle", trap_squash, 0);

      // Waiting for drain, latency 0, latency input changed after entry
      repeat (2) @(negedge clk);
      rob_empty = 0; k = cyc; irq_req = 1; irq_cause = 6'd12; trap_latency = 8'd0;
      @(negedge clk); irq_req = 0;
      check("R2 irq_to_fetch after request", irq_to_fetch, 1);
      repeat (4) @(negedge clk);
      check("R3 held while buffer busy", irq_to_fetch, 1);
      check("R3 no trap while buffer busy", trap_pending, 0);
      rob_empty = 1; stores_pending = 1;
      repeat (3) @(negedge clk);
      check("R3 held while stores pending", irq_to_fetch, 1);
      check("R3 no trap while stores pending", trap_pending, 0);
      m = cyc; stores_pending = 0;
      push(0, m + 1, 12); push(1, m + 3, 0);
      @(negedge clk); trap_latency = 8'd7;
      wait_until(m + 3);
      check("R6 zero latency squash", trap_squash, 1);
      check("R7 trap_pending low with squash", trap_pending, 0);
      wait_until(m + 4);
      check("R11 trap_squash single cycle", trap_squash, 0);

      // Disabled interrupts are ignored
      repeat (2) @(negedge clk);
      irq_enable = 0; irq_req = 1; irq_cause = 6'd3;
      repeat (3) @(negedge clk);
      check("R2 disabled request ignored", irq_to_fetch, 0);
      irq_req = 0; irq_enable = 1;
      @(negedge clk);
      check("R2 disabled request not latched", irq_to_fetch, 0);

      // Requests during a trap in flight are dropped
      trap_latency = 8'd6;
      k = cyc; irq_req = 1; irq_cause = 6'd20;
      push(0, k + 2, 20); push(1, k + 10, 0);
      @(negedge clk); irq_req = 0;
      wait_until(k + 3);
      irq_req = 1; irq_cause = 6'd9; ctx_squash_req = 1;
      @(negedge clk); ctx_squash_req = 0;
      check("R2 request blocked while trap pending", irq_to_fetch, 0);
      wait_until(k + 5);
      check("R8 ctx request dropped during trap", ctx_squash, 0);
      wait_until(k + 8); irq_req = 0;
      check("R2 still blocked while trap pending", irq_to_fetch, 0);
      wait_until(k + 10);
      check("R7 trap_pending cleared", trap_pending, 0);
      wait_until(k + 14);
      check("R2 no late latch of blocked request", irq_to_fetch, 0);
      check("R8 no late ctx squash", thread_squashing, 0);

      // Context squash while idle
      rob_empty = 0; k = cyc; ctx_squash_req = 1;
      push(2, k + 2, 0);
      @(negedge clk); ctx_squash_req = 0;
      wait_until(k + 2);
      check("R8 ctx_squash pulse", ctx_squash, 1);
      check("R8 thread_squashing rises", thread_squashing, 1);
      wait_until(k + 4);
      check("R9 squashing held while buffer busy", thread_squashing, 1);
      check("R8 ctx_squash single cycle", ctx_squash, 0);
      rob_empty = 1;
      wait_until(k + 5);
      check("R9 squashing ends after empty", thread_squashing, 0);

      // Context request accepted on the entry edge
      repeat (2) @(negedge clk);
      trap_latency = 8'd1; k = cyc; irq_req = 1; irq_cause = 6'd33;
      push(0, k + 2, 33);
      @(negedge clk); irq_req = 0; ctx_squash_req = 1;
      push(2, k + 3, 0); push(1, k + 5, 0);
      @(negedge clk); ctx_squash_req = 0;
      wait_until(k + 3);
      check("R10 ctx served alone", {trap_squash, ctx_squash}, 1);
      wait_until(k + 5);
      check("R10 trap served alone", {trap_squash, ctx_squash}, 2);

      repeat (6) @(negedge clk);
      check("R5 all expected pulses observed", exp_q.size(), 0);
      done = 1;
      finish_run();
   end
endmodule